// File: doc/BRIEF.md
# Register Window State Controller

This block keeps the window bookkeeping for a register file that is split into a ring of overlapping windows. It holds the current window pointer and four counters: windows free to save into, windows that can be restored, clean windows, and windows that belong to another context. The register file, and the choice of trap vector, live elsewhere.

A caller issues one operation per cycle: save, restore or flush-windows. The controller moves the pointer and updates the counters. When the operation cannot complete, it reports a spill, fill or clean-window trap. A spill or fill trap carries an "other" flag that is set when the other-context counter is nonzero. A privileged write port loads the pointer or any counter directly.

Every operation is registered. Its result strobe, trap flags and new state all appear together, one clock after the request.

Top module: `regwin_ctrl`

## Requirements
- R1: After reset the pointer is 0, the save counter is NWIN-2, and the restore, clean and other counters are 0.
- R2: A save with a nonzero save counter and a clean counter different from the restore counter raises no trap. It advances the pointer by 1, decrements the save counter and increments the restore counter.
- R3: A save with a save counter of 0 raises a spill trap and advances the pointer by 2 modulo NWIN. The counters do not change.
- R4: A save with a nonzero save counter and a clean counter equal to the restore counter raises a clean-window trap and advances the pointer by 1. The counters do not change.
- R5: A restore with a nonzero restore counter raises no trap. It moves the pointer back by 1, increments the save counter and decrements the restore counter.
- R6: A restore with a restore counter of 0 raises a fill trap. The pointer still moves back by 1 and the counters do not change.
- R7: The other flag is 1 on a spill or fill trap when the other counter is nonzero, and 0 otherwise. It is always 0 on a clean-window trap.
- R8: A flush-windows operation never moves the pointer or the counters. It raises a spill trap exactly when NWIN-2 minus the save counter is nonzero.
- R9: The write port selects a target with `wr_sel`: 0 pointer, 1 save counter, 2 restore counter, 3 clean counter, 4 other counter. It loads `wr_data` into that target. When `wr_en` is high, an operation requested in the same cycle is dropped: no strobe, no trap, no state change apart from the write.
- R10: `res_valid` pulses for one cycle, one clock after each accepted operation. At most one trap flag is high, and only together with `res_valid`.
- R11: The pointer wraps modulo NWIN in both directions.
- R12: Operation codes are 0 save, 1 restore, 2 flush-windows. Code 3 is ignored: no strobe and no state change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation request |
| op_code | input | 2 | 0 save, 1 restore, 2 flush-windows, 3 ignored |
| wr_en | input | 1 | Privileged write enable |
| wr_sel | input | 3 | Write target select |
| wr_data | input | clog2(NWIN) | Write value |
| cwp | output | clog2(NWIN) | Current window pointer |
| cansave | output | clog2(NWIN) | Windows free to save into |
| canrestore | output | clog2(NWIN) | Windows that can be restored |
| cleanwin | output | clog2(NWIN) | Clean window count |
| otherwin | output | clog2(NWIN) | Other-context window count |
| res_valid | output | 1 | Result strobe for an accepted operation |
| trap_spill | output | 1 | Spill trap |
| trap_fill | output | 1 | Fill trap |
| trap_clean | output | 1 | Clean-window trap |
| trap_other | output | 1 | Trap uses the other-context variant |

## Verification
Saves are issued in each of the three counter states: the save counter at zero, clean equal to restore, and the normal case. This separates the spill, clean-window and success paths, and shows the pointer moving by 2 on a spill and by 1 otherwise. Restores are issued with the restore counter both nonzero and zero, with the pointer at 0 so that the backward wrap is visible. Spill and fill traps are raised with the other counter zero and nonzero. Flush-windows is applied with the save counter below NWIN-2 and at NWIN-2, which separates trapping from silent completion. A write that coincides with a save, and the unused operation code, show that these requests leave no strobe and no state change.

// File: rtl/regwin_ctrl.sv
module regwin_ctrl #(
  parameter int NWIN = 8,
  localparam int PW = $clog2(NWIN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic [1:0]    op_code,
  input  logic          wr_en,
  input  logic [2:0]    wr_sel,
  input  logic [PW-1:0] wr_data,
  output logic [PW-1:0] cwp,
  output logic [PW-1:0] cansave,
  output logic [PW-1:0] canrestore,
  output logic [PW-1:0] cleanwin,
  output logic [PW-1:0] otherwin,
  output logic          res_valid,
  output logic          trap_spill,
  output logic          trap_fill,
  output logic          trap_clean,
  output logic          trap_other
);

  localparam logic [1:0] OP_SAVE    = 2'd0;
  localparam logic [1:0] OP_RESTORE = 2'd1;
  localparam logic [1:0] OP_FLUSH   = 2'd2;

  function automatic logic [PW-1:0] ring_add(input logic [PW-1:0] p, input int k);
    int t;
    t = int'(p) + k;
    if (t >= NWIN) t = t - NWIN;
    return t[PW-1:0];
  endfunction

  logic          take_op;
  logic          is_save, is_rest, is_flush;
  logic          save_spill, save_clean, rest_fill, flush_spill;
  logic          other_nz;
  logic [PW-1:0] ptr_fwd1, ptr_fwd2, ptr_back1;

  assign take_op   = op_valid && !wr_en && (op_code != 2'd3);
  assign is_save   = take_op && op_code == OP_SAVE;
  assign is_rest   = take_op && op_code == OP_RESTORE;
  assign is_flush  = take_op && op_code == OP_FLUSH;

  assign save_spill  = cansave == '0;
  assign save_clean  = !save_spill && (cleanwin == canrestore);
  assign rest_fill   = canrestore == '0;
  assign flush_spill = (NWIN - 2 - int'(cansave)) != 0;
  assign other_nz    = otherwin != '0;

  assign ptr_fwd1  = ring_add(cwp, 1);
  assign ptr_fwd2  = ring_add(cwp, 2);
  assign ptr_back1 = ring_add(cwp, NWIN - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cwp        <= '0;
      cansave    <= PW'(NWIN - 2);
      canrestore <= '0;
      cleanwin   <= '0;
      otherwin   <= '0;
      res_valid  <= 1'b0;
      trap_spill <= 1'b0;
      trap_fill  <= 1'b0;
      trap_clean <= 1'b0;
      trap_other <= 1'b0;
    end else begin
      res_valid  <= take_op;
      trap_spill <= 1'b0;
      trap_fill  <= 1'b0;
      trap_clean <= 1'b0;
      trap_other <= 1'b0;
      if (wr_en) begin
        case (wr_sel)
          3'd0: if (int'(wr_data) < NWIN) cwp <= wr_data;
          3'd1: cansave    <= wr_data;
          3'd2: canrestore <= wr_data;
          3'd3: cleanwin   <= wr_data;
          3'd4: otherwin   <= wr_data;
          default: ;
        endcase
      end else if (is_save) begin
        if (save_spill) begin
          cwp        <= ptr_fwd2;
          trap_spill <= 1'b1;
          trap_other <= other_nz;
        end else if (save_clean) begin
          cwp        <= ptr_fwd1;
          trap_clean <= 1'b1;
        end else begin
          cwp        <= ptr_fwd1;
          cansave    <= cansave - 1'b1;
          canrestore <= canrestore + 1'b1;
        end
      end else if (is_rest) begin
        cwp <= ptr_back1;
        if (rest_fill) begin
          trap_fill  <= 1'b1;
          trap_other <= other_nz;
        end else begin
          cansave    <= cansave + 1'b1;
          canrestore <= canrestore - 1'b1;
        end
      end else if (is_flush) begin
        if (flush_spill) begin
          trap_spill <= 1'b1;
          trap_other <= other_nz;
        end
      end
    end
  end

  AST_ONE_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({trap_spill, trap_fill, trap_clean}));  // R10
  AST_TRAP_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_spill || trap_fill || trap_clean) |-> res_valid);  // R10
  AST_OTHER_SPILL_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    trap_other |-> (trap_spill || trap_fill));  // R7
  AST_RESTORE_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !wr_en && op_code == OP_RESTORE) |=> (cwp == ring_add($past(cwp), NWIN - 1)));  // R6
  AST_FILL_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !wr_en && op_code == OP_RESTORE && canrestore == '0) |=> trap_fill);  // R6
  AST_WRITE_DROPS_OP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !res_valid);  // R9
  AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cwp) < NWIN);  // R11
  AST_FLUSH_HOLDS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !wr_en && op_code == OP_FLUSH) |=> $stable(cwp));  // R8

endmodule

// File: tb/regwin_ctrl_test.sv
`timescale 1ns/1ps
module regwin_ctrl_test;
  localparam int NWIN = 8;
  localparam int PW = $clog2(NWIN);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_valid = 1'b0;
  logic [1:0] op_code = 2'd0;
  logic wr_en = 1'b0;
  logic [2:0] wr_sel = 3'd0;
  logic [PW-1:0] wr_data = '0;
  logic [PW-1:0] cwp, cansave, canrestore, cleanwin, otherwin;
  logic res_valid, trap_spill, trap_fill, trap_clean, trap_other;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  regwin_ctrl #(.NWIN(NWIN)) uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .cwp(cwp), .cansave(cansave), .canrestore(canrestore),
    .cleanwin(cleanwin), .otherwin(otherwin), .res_valid(res_valid),
    .trap_spill(trap_spill), .trap_fill(trap_fill),
    .trap_clean(trap_clean), .trap_other(trap_other)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_state(input string tag, input int p, input int cs, input int cr,
                           input int cw, input int ow);
    chk({tag, " ptr"}, int'(cwp), p);
    chk({tag, " cansave"}, int'(cansave), cs);
    chk({tag, " canrestore"}, int'(canrestore), cr);
    chk({tag, " cleanwin"}, int'(cleanwin), cw);
    chk({tag, " otherwin"}, int'(otherwin), ow);
  endtask

  task automatic chk_out(input string tag, input int v, input int s, input int f,
                         input int c, input int o);
    chk({tag, " valid"}, int'(res_valid), v);
    chk({tag, " spill"}, int'(trap_spill), s);
    chk({tag, " fill"}, int'(trap_fill), f);
    chk({tag, " clean"}, int'(trap_clean), c);
    chk({tag, " other"}, int'(trap_other), o);
  endtask

  task automatic do_op(input logic [1:0] code);
    @(negedge clk);
    op_valid = 1'b1; op_code = code;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic do_wr(input logic [2:0] sel, input int val);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = PW'(val);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic t_reset;
    chk_state("R1 reset", 0, NWIN - 2, 0, 0, 0);
    chk_out("R1 reset", 0, 0, 0, 0, 0);
  endtask

  task automatic t_save_clean;
    do_op(2'd0);
    chk_out("R4 clean save", 1, 0, 0, 1, 0);
    chk_state("R4 clean save", 1, 6, 0, 0, 0);
    @(negedge clk);
    chk_out("R10 pulse ends", 0, 0, 0, 0, 0);
  endtask

  task automatic t_save_ok;
    do_wr(3'd3, 7);
    chk_state("R9 write cleanwin", 1, 6, 0, 7, 0);
    do_op(2'd0);
    chk_out("R2 save ok", 1, 0, 0, 0, 0);
    chk_state("R2 save ok", 2, 5, 1, 7, 0);
  endtask

  task automatic t_restore;
    do_op(2'd1);
    chk_out("R5 restore ok", 1, 0, 0, 0, 0);
    chk_state("R5 restore ok", 1, 6, 0, 7, 0);
    do_op(2'd1);
    chk_out("R6 fill normal", 1, 0, 1, 0, 0);
    chk_state("R6 fill normal", 0, 6, 0, 7, 0);
    do_op(2'd1);
    chk_out("R11 fill wrap", 1, 0, 1, 0, 0);
    chk_state("R11 wrap back", 7, 6, 0, 7, 0);
    do_wr(3'd4, 2);
    do_op(2'd1);
    chk_out("R7 fill other", 1, 0, 1, 0, 1);
    chk_state("R7 fill other", 6, 6, 0, 7, 2);
  endtask

  task automatic t_spill;
    do_wr(3'd1, 0);
    do_op(2'd0);
    chk_out("R3 spill other", 1, 1, 0, 0, 1);
    chk_state("R3 R11 spill wrap", 0, 0, 0, 7, 2);
    do_wr(3'd4, 0);
    do_op(2'd0);
    chk_out("R7 spill normal", 1, 1, 0, 0, 0);
    chk_state("R3 spill", 2, 0, 0, 7, 0);
  endtask

  task automatic t_flush;
    do_op(2'd2);
    chk_out("R8 flush spill", 1, 1, 0, 0, 0);
    chk_state("R8 flush spill", 2, 0, 0, 7, 0);
    do_wr(3'd1, NWIN - 2);
    do_op(2'd2);
    chk_out("R8 flush quiet", 1, 0, 0, 0, 0);
    chk_state("R8 flush quiet", 2, 6, 0, 7, 0);
  endtask

  task automatic t_write_priority;
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 3'd1; wr_data = PW'(3);
    op_valid = 1'b1; op_code = 2'd0;
    @(negedge clk);
    wr_en = 1'b0; op_valid = 1'b0;
    chk_out("R9 write wins", 0, 0, 0, 0, 0);
    chk_state("R9 write wins", 2, 3, 0, 7, 0);
    do_wr(3'd0, 5);
    chk_state("R9 write ptr", 5, 3, 0, 7, 0);
  endtask

  task automatic t_bad_code;
    do_op(2'd3);
    chk_out("R12 code3 ignored", 0, 0, 0, 0, 0);
    chk_state("R12 code3 ignored", 5, 3, 0, 7, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_save_clean();
    t_save_ok();
    t_restore();
    t_spill();
    t_flush();
    t_write_priority();
    t_bad_code();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule